// File: doc/BRIEF.md
# Maskable Interrupt Enable and Mode Controller

This block keeps the interrupt-related state of an 8-bit processor core: two interrupt enable flags, the active service mode, and a halted flag. The core drives single-cycle command pulses when it executes instructions that disable or enable interrupts, select one of three service modes, or halt. It also pulses a completion strobe at the end of every instruction. The block watches a level-sensitive maskable request line and decides at each instruction boundary whether to take the interrupt.

When it takes an interrupt, the block raises a one-cycle strobe. Alongside the strobe it reports the mode that was in force and a 16-bit service value. In bus mode that value carries the opcode byte that the acknowledging device placed on the data bus, and the core executes that byte next. In restart mode the value is the fixed restart address. In table mode the value is the address of a vector-table entry, formed from the core's vector register as the high byte and the bus byte as the low byte.

An enable instruction takes effect one instruction late, so that the instruction after it always runs before any interrupt is taken. While the core is halted, every cycle counts as a boundary, so a pending request wakes it.

Top module: `intc_ctrl`

## Requirements
- R1: After reset, both enable flags are 0, the mode is 0 (bus), halted is 0 and the take strobe is 0.
- R2: A disable pulse clears both enable flags on the next clock edge. If a disable pulse and an enable pulse arrive in the same cycle, the disable wins.
- R3: An enable pulse without a disable pulse sets both enable flags on the next clock edge.
- R4: A request is never taken at the boundary that ends the enable instruction itself, whether the enable pulse comes with that completion or before it. It can be taken at the next boundary after that one.
- R5: A request is taken only in a cycle that is a boundary (completion strobe high, or halted high), with the request high, enable flag 1 set and no disable or enable pulse present. The take strobe goes high on the following edge and stays high for exactly one cycle.
- R6: Taking a request clears both enable flags on the same edge that raises the take strobe.
- R7: In mode 0 (bus), the service value is 0x00 in the high byte and the acknowledge bus byte in the low byte, and the reported take mode is 0.
- R8: In mode 1 (restart), the service value is 0x0038 regardless of the vector register and the bus byte.
- R9: In mode 2 (table), the service value is the vector register as the high byte and the bus byte as the low byte.
- R10: Mode select is a 3-bit pulse vector in which bit i selects mode i. If several bits are high in one cycle, the highest-numbered bit wins. The new mode is visible on the next edge.
- R11: A halt pulse sets halted on the next edge. Halted stays set until a request is taken, and taking a request clears it. While halted with interrupts disabled, requests are ignored.
- R12: A disable pulse at a boundary blocks the take in that cycle, even when the request is high and interrupts were enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_di | input | 1 | Disable-interrupts pulse |
| cmd_ei | input | 1 | Enable-interrupts pulse |
| cmd_im | input | 3 | Mode select pulses, bit i selects mode i |
| cmd_halt | input | 1 | Halt pulse |
| insn_done | input | 1 | Instruction completion strobe |
| irq_req | input | 1 | Maskable interrupt request level |
| vec_reg | input | 8 | Vector register (table page) |
| ack_byte | input | 8 | Byte on the data bus during acknowledge |
| ien1 | output | 1 | Enable flag 1 |
| ien2 | output | 1 | Enable flag 2 |
| irq_mode | output | 2 | Current service mode |
| halted | output | 1 | Core is halted |
| take_stb | output | 1 | One-cycle interrupt-taken strobe |
| take_mode | output | 2 | Mode in force when the request was taken |
| svc_addr | output | 16 | Service value for the taken request |

## Verification
The hardest situation to reach from the ports is the delayed enable. The enable pulse must arrive ahead of the completion strobe of its own instruction, and the request must already be high at that boundary, so that a take happening one boundary too early would be visible. The bench produces both orderings: an enable pulse together with its completion strobe, and an enable pulse followed by a separate completion strobe. In each case the request is held high from the enable onward. The wake-from-halt paths also need setup through the ports alone. The bench first enables interrupts, then halts, and then raises the request with no completion strobe. It repeats this with interrupts disabled to show that the request is ignored.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int NMODE = 3;
  localparam int MW = $clog2(NMODE);
  localparam logic [AW-1:0] RST_TARGET = 16'h0038;

  typedef enum logic [MW-1:0] {
    IM_BUS   = 2'd0,
    IM_RST   = 2'd1,
    IM_TABLE = 2'd2
  } imode_t;

  // service value for a taken request, per mode
  function automatic logic [AW-1:0] svc_target(imode_t m, logic [DW-1:0] vec,
                                               logic [DW-1:0] bus);
    logic [AW-1:0] r;
    case (m)
      IM_RST:   r = RST_TARGET;
      IM_TABLE: r = {vec, bus};
      default:  r = {{(AW-DW){1'b0}}, bus};
    endcase
    return r;
  endfunction

  // highest-numbered select bit wins; keep current mode if none set
  function automatic imode_t pick_mode(logic [NMODE-1:0] sel, imode_t cur);
    imode_t r;
    r = cur;
    for (int i = 0; i < NMODE; i++)
      if (sel[i]) r = imode_t'(MW'(i));
    return r;
  endfunction
endpackage

// File: rtl/intc_enable_ff.sv
module intc_enable_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_di,
  input  logic cmd_ei,
  input  logic insn_done,
  input  logic accept,
  output logic ien1,
  output logic ien2,
  output logic ei_shadow
);
  logic ien_n, shadow_n;

  always_comb begin
    ien_n = ien1;
    if (cmd_di)      ien_n = 1'b0;
    else if (cmd_ei) ien_n = 1'b1;
    else if (accept) ien_n = 1'b0;
  end

  // shadow covers the window up to the boundary ending the enable instruction
  always_comb begin
    if (cmd_ei && !cmd_di) shadow_n = !insn_done;
    else if (insn_done || cmd_di) shadow_n = 1'b0;
    else shadow_n = ei_shadow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien1      <= 1'b0;
      ien2      <= 1'b0;
      ei_shadow <= 1'b0;
    end else begin
      ien1      <= ien_n;
      ien2      <= ien_n;
      ei_shadow <= shadow_n;
    end
  end
endmodule

// File: rtl/intc_mode_reg.sv
module intc_mode_reg
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NMODE-1:0] cmd_im,
  output imode_t           mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) mode <= IM_BUS;
    else        mode <= pick_mode(cmd_im, mode);
  end
endmodule

// File: rtl/intc_halt_ff.sv
module intc_halt_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_halt,
  input  logic accept,
  output logic halted
);
  always_ff @(posedge clk) begin
    if (!rst_n)        halted <= 1'b0;
    else if (accept)   halted <= 1'b0;
    else if (cmd_halt) halted <= 1'b1;
  end
endmodule

// File: rtl/intc_target_reg.sv
module intc_target_reg
  import intc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  imode_t        mode,
  input  logic [DW-1:0] vec,
  input  logic [DW-1:0] bus,
  output logic          take_stb,
  output imode_t        take_mode,
  output logic [AW-1:0] svc_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_stb  <= 1'b0;
      take_mode <= IM_BUS;
      svc_addr  <= '0;
    end else begin
      take_stb <= accept;
      if (accept) begin
        take_mode <= mode;
        svc_addr  <= svc_target(mode, vec, bus);
      end
    end
  end
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_di,
  input  logic             cmd_ei,
  input  logic [NMODE-1:0] cmd_im,
  input  logic             cmd_halt,
  input  logic             insn_done,
  input  logic             irq_req,
  input  logic [DW-1:0]    vec_reg,
  input  logic [DW-1:0]    ack_byte,
  output logic             ien1,
  output logic             ien2,
  output logic [MW-1:0]    irq_mode,
  output logic             halted,
  output logic             take_stb,
  output logic [MW-1:0]    take_mode,
  output logic [AW-1:0]    svc_addr
);
  logic   ei_shadow;
  logic   boundary_w;
  logic   accept_w;
  imode_t mode_q;
  imode_t take_mode_q;

  assign boundary_w = insn_done | halted;
  assign accept_w   = boundary_w & irq_req & ien1 & ~ei_shadow & ~cmd_ei & ~cmd_di;

  intc_enable_ff u_en (
    .clk(clk), .rst_n(rst_n), .cmd_di(cmd_di), .cmd_ei(cmd_ei),
    .insn_done(insn_done), .accept(accept_w),
    .ien1(ien1), .ien2(ien2), .ei_shadow(ei_shadow)
  );

  intc_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .cmd_im(cmd_im), .mode(mode_q)
  );

  intc_halt_ff u_halt (
    .clk(clk), .rst_n(rst_n), .cmd_halt(cmd_halt), .accept(accept_w),
    .halted(halted)
  );

  intc_target_reg u_tgt (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .mode(mode_q),
    .vec(vec_reg), .bus(ack_byte),
    .take_stb(take_stb), .take_mode(take_mode_q), .svc_addr(svc_addr)
  );

  assign irq_mode  = mode_q;
  assign take_mode = take_mode_q;
endmodule

// File: rtl/intc_ctrl_chk.sv
module intc_ctrl_chk
  import intc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_di,
  input logic          cmd_ei,
  input logic          irq_req,
  input logic          ien1,
  input logic          ien2,
  input logic          halted,
  input logic          take_stb,
  input logic [MW-1:0] take_mode,
  input logic [AW-1:0] svc_addr,
  input logic          ei_shadow,
  input logic          accept_w
);
  assert_di_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di |=> (!ien1 && !ien2));
  assert_ei_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ei && !cmd_di) |=> (ien1 && ien2));
  assert_shadow_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ei_shadow |-> !accept_w);
  assert_take_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |=> !take_stb);
  assert_take_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> (ien1 && irq_req));
  assert_take_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |-> (!ien1 && !ien2));
  assert_restart_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_stb && take_mode == 2'd1) |-> (svc_addr == RST_TARGET));
  assert_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take_stb |-> !halted);
  assert_di_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !$past(cmd_di));
endmodule

bind intc_ctrl intc_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .cmd_di(cmd_di), .cmd_ei(cmd_ei),
  .irq_req(irq_req), .ien1(ien1), .ien2(ien2), .halted(halted),
  .take_stb(take_stb), .take_mode(take_mode), .svc_addr(svc_addr),
  .ei_shadow(ei_shadow), .accept_w(accept_w)
);

// File: tb/intc_ctrl_test.sv
module intc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_di, cmd_ei, cmd_halt, insn_done, irq_req;
  logic [2:0] cmd_im;
  logic [7:0] vec_reg, ack_byte;
  logic ien1, ien2, halted, take_stb;
  logic [1:0] irq_mode, take_mode;
  logic [15:0] svc_addr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_di(cmd_di), .cmd_ei(cmd_ei),
    .cmd_im(cmd_im), .cmd_halt(cmd_halt), .insn_done(insn_done),
    .irq_req(irq_req), .vec_reg(vec_reg), .ack_byte(ack_byte),
    .ien1(ien1), .ien2(ien2), .irq_mode(irq_mode), .halted(halted),
    .take_stb(take_stb), .take_mode(take_mode), .svc_addr(svc_addr)
  );

  // {mode[33:32], vec[31:24], ack[23:16], expected service value[15:0]}
  localparam logic [33:0] VECS [6] = '{
    {2'd0, 8'h12, 8'hC7, 16'h00C7},
    {2'd1, 8'h12, 8'h55, 16'h0038},
    {2'd2, 8'h12, 8'h34, 16'h1234},
    {2'd2, 8'hFF, 8'hFE, 16'hFFFE},
    {2'd0, 8'hAB, 8'hFF, 16'h00FF},
    {2'd1, 8'h00, 8'h00, 16'h0038}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cmd_di = 0; cmd_ei = 0; cmd_im = 3'b000; cmd_halt = 0; insn_done = 0;
  endtask

  task automatic do_reset();
    idle(); irq_req = 0; rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  initial begin
    vec_reg = 8'h00; ack_byte = 8'h00;
    do_reset();
    // R1 reset state
    check(ien1 == 0 && ien2 == 0, "R1 enables", {ien1, ien2}, 0);
    check(irq_mode == 0, "R1 mode", irq_mode, 0);
    check(halted == 0, "R1 halted", halted, 0);
    check(take_stb == 0, "R1 take", take_stb, 0);

    // table walk: R7 R8 R9 with R4 R5 R6 R10
    for (int i = 0; i < 6; i++) begin
      logic [1:0] m;
      m = VECS[i][33:32];
      cmd_im = 3'b001 << m; step(); idle();
      check(irq_mode == m, "R10 mode select", irq_mode, m);
      vec_reg = VECS[i][31:24]; ack_byte = VECS[i][23:16];
      cmd_ei = 1; insn_done = 1; irq_req = 1; step(); idle();
      check(take_stb == 0, "R4 no take at enable boundary", take_stb, 0);
      check(ien1 && ien2, "R3 enables set", {ien1, ien2}, 3);
      insn_done = 1; step(); idle(); irq_req = 0;
      check(take_stb == 1, "R5 take", take_stb, 1);
      check(svc_addr == VECS[i][15:0], "R7/R8/R9 service value", svc_addr, VECS[i][15:0]);
      check(take_mode == m, "R7 take mode", take_mode, m);
      check(!ien1 && !ien2, "R6 enables cleared", {ien1, ien2}, 0);
      step();
      check(take_stb == 0, "R5 single strobe", take_stb, 0);
    end

    // R4: enable pulse ahead of its own completion
    do_reset();
    irq_req = 1;
    cmd_ei = 1; step(); idle();
    check(take_stb == 0, "R4 early ei no take", take_stb, 0);
    insn_done = 1; step(); idle();
    check(take_stb == 0, "R4 ei boundary no take", take_stb, 0);
    insn_done = 1; step(); idle();
    check(take_stb == 1, "R4 next boundary takes", take_stb, 1);
    irq_req = 0; step();

    // R5: enabled but no boundary, and boundary but disabled
    cmd_ei = 1; insn_done = 1; step(); idle();
    irq_req = 1; step(); step();
    check(take_stb == 0, "R5 no boundary no take", take_stb, 0);
    cmd_di = 1; step(); idle();
    check(!ien1 && !ien2, "R2 disable", {ien1, ien2}, 0);
    insn_done = 1; step(); idle();
    check(take_stb == 0, "R5 disabled no take", take_stb, 0);
    irq_req = 0;

    // R2: disable wins over enable in same cycle
    cmd_ei = 1; cmd_di = 1; step(); idle();
    check(!ien1, "R2 di beats ei", ien1, 0);

    // R12: disable at boundary blocks take
    cmd_ei = 1; insn_done = 1; step(); idle();
    irq_req = 1; insn_done = 1; cmd_di = 1; step(); idle();
    check(take_stb == 0, "R12 di blocks take", take_stb, 0);
    step();
    check(take_stb == 0 && !ien1, "R12 stays blocked", take_stb, 0);
    irq_req = 0;

    // R10: several mode bits at once
    cmd_im = 3'b011; step(); idle();
    check(irq_mode == 1, "R10 priority 1 over 0", irq_mode, 1);
    cmd_im = 3'b111; step(); idle();
    check(irq_mode == 2, "R10 priority 2", irq_mode, 2);

    // R11: halt then wake
    cmd_ei = 1; insn_done = 1; step(); idle();
    cmd_halt = 1; insn_done = 1; step(); idle();
    check(halted == 1, "R11 halted set", halted, 1);
    step(); step();
    check(halted == 1 && take_stb == 0, "R11 halted holds", halted, 1);
    vec_reg = 8'h40; ack_byte = 8'h10; irq_req = 1; step(); irq_req = 0;
    check(take_stb == 1, "R11 wake take", take_stb, 1);
    check(halted == 0, "R11 halted cleared", halted, 0);
    check(svc_addr == 16'h4010, "R9 wake table value", svc_addr, 16'h4010);

    // R11: halted with interrupts disabled ignores request
    cmd_di = 1; step(); idle();
    cmd_halt = 1; insn_done = 1; step(); idle();
    irq_req = 1; step(); step(); step();
    check(halted == 1, "R11 disabled stays halted", halted, 1);
    check(take_stb == 0, "R11 disabled no take", take_stb, 0);
    irq_req = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule